// File: doc/BRIEF.md
# Store Gathering Write Buffer

This block sits on the write path between a processor's store pipeline and a memory bus. It collects successive stores whose bytes follow on from one another inside the same aligned chunk and sends them as one wide bus write, with a byte-enable mask that marks exactly the bytes that were written. When fewer bus writes carry the same data, less bus bandwidth is used and fewer transactions are needed.

Some stores never merge with another store. A store marked little-endian and a store marked floating-point each leave as their own bus write. An ordering barrier pulse closes the gather that is being built, so stores on opposite sides of the barrier never share a write. A global enable turns merging off altogether. An open gather is also sent when its chunk is completely filled or when no new store has joined it for a programmable number of cycles. Bus writes keep the order of the stores that produced them. The store input is held off with ready whenever taking a store would require an output slot that is still waiting on the bus.

Top module: `store_gather_buf`

## Requirements
- R1: After reset no bus write is pending (`bw_valid` low) and, with gathering enabled and no store offered, `st_ready` is high.
- R2: A store carries 1, 2, 4 or 8 bytes (`st_size` 0, 1, 2, 3), naturally aligned. Byte i of `st_data` goes to byte lane (`st_addr` mod 32)+i. `bw_addr` is the 32-byte-aligned chunk address. A store whose first byte is the byte right after the last collected byte of the open gather, in the same chunk, joins that gather.
- R3: A store that falls in a different chunk, or that leaves a gap after (or overlaps) the collected bytes, starts a new bus write. The open gather is sent first.
- R4: `bw_be` bit k is set exactly when some store in that write wrote lane k. `bw_data` lane k holds that byte.
- R5: A store with `st_le` high is never merged. It forms a bus write of its own.
- R6: A store with `st_fp` high is never merged. It forms a bus write of its own.
- R7: A one-cycle `barrier` pulse closes the open gather. No store accepted before the pulse shares a bus write with a store accepted after it.
- R8: While `gather_en` is low, every store is its own bus write, and any open gather is sent.
- R9: A gather whose 32 lanes are all written is sent without waiting for another store or a barrier.
- R10: An open gather that no store has joined for `idle_limit` cycles is sent with no further input. It is not sent before that.
- R11: Bus writes leave in the order of the stores that produced them.
- R12: While `bw_valid` is high and `bw_ready` is low, `bw_addr`, `bw_data` and `bw_be` hold steady. A store that needs the output slot is held off with `st_ready` low, so no store is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gather_en | input | 1 | Merging allowed when high |
| idle_limit | input | IDLE_W | Idle cycles before an open gather is sent |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted this cycle when high together with st_valid |
| st_addr | input | ADDR_W | Byte address of the store |
| st_data | input | ST_BYTES*8 | Store bytes, first byte in the low lane |
| st_size | input | 2 | Log2 of the store length in bytes |
| st_le | input | 1 | Store is little-endian, never merged |
| st_fp | input | 1 | Store is floating-point, never merged |
| barrier | input | 1 | Ordering barrier pulse |
| bw_valid | output | 1 | Bus write valid |
| bw_ready | input | 1 | Bus accepts the write |
| bw_addr | output | ADDR_W | Chunk-aligned bus address |
| bw_data | output | CHUNK_BYTES*8 | Bus data beat |
| bw_be | output | CHUNK_BYTES | Byte enables of the beat |

## Verification
The bench uses the default shape: a 32-bit address, 32-byte chunks and 8-byte stores. A 32-byte chunk is filled by four 8-byte stores, so the full-chunk flush can be reached with short directed sequences. The 10-bit idle limit is driven to 4 for the timeout case and to its maximum elsewhere, which keeps timeouts out of the random phase. The random addresses stay within a 256-byte window that spans eight chunks, so merges, chunk crossings, full chunks and excluded stores all occur often under random bus back-pressure.

// File: rtl/sgb_pkg.sv
package sgb_pkg;

   // what the accepted store does to the gather state this cycle
   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_OPEN   = 2'd1,
      ACT_MERGE  = 2'd2,
      ACT_DIRECT = 2'd3
   } st_act_e;

   // log2 size code to byte count
   function automatic logic [3:0] sz_bytes(input logic [1:0] code);
      return 4'd1 << code;
   endfunction

endpackage

// File: rtl/sgb_lane_place.sv
module sgb_lane_place
   import sgb_pkg::*;
#(
   parameter int CHUNK_BYTES = 32,
   parameter int ST_BYTES    = 8,
   parameter int OFF_W       = $clog2(CHUNK_BYTES)
) (
   input  logic [OFF_W-1:0]         off,
   input  logic [1:0]               size,
   input  logic [ST_BYTES*8-1:0]    data,
   output logic [OFF_W:0]           nbytes,
   output logic [CHUNK_BYTES*8-1:0] lane_data,
   output logic [CHUNK_BYTES-1:0]   lane_be
);

   localparam int SIDX_W = (ST_BYTES > 1) ? $clog2(ST_BYTES) : 1;

   assign nbytes = (OFF_W+1)'(sz_bytes(size));

   // each lane picks its byte from the store by its distance to the start offset
   for (genvar ln = 0; ln < CHUNK_BYTES; ln++) begin : g_lane
      logic [OFF_W:0] rel;
      logic           hit;
      assign rel = (OFF_W+1)'(ln) - {1'b0, off};
      assign hit = rel < nbytes;
      assign lane_be[ln] = hit;
      assign lane_data[ln*8 +: 8] = hit ? data[{rel[SIDX_W-1:0], 3'b000} +: 8] : 8'h00;
   end

endmodule

// File: rtl/sgb_gather_ctl.sv
module sgb_gather_ctl
   import sgb_pkg::*;
#(
   parameter int CH_W  = 27,
   parameter int OFF_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gather_en,
   input  logic             st_valid,
   input  logic             st_le,
   input  logic             st_fp,
   input  logic             barrier,
   input  logic [CH_W-1:0]  st_chunk,
   input  logic [OFF_W-1:0] st_off,
   input  logic             g_open,
   input  logic [CH_W-1:0]  g_base,
   input  logic [OFF_W:0]   g_next,
   input  logic             g_close_req,
   input  logic             g_full,
   input  logic             g_timeout,
   input  logic             out_free,
   output logic             st_ready,
   output st_act_e          act,
   output logic             flush_fire,
   output logic             close_set
);

   logic excl, same, blocked, merge_ok, close_want;

   assign excl     = st_le | st_fp | ~gather_en;
   assign same     = g_open && (st_chunk == g_base) && ({1'b0, st_off} == g_next);
   assign blocked  = barrier | g_close_req | g_full | g_timeout | ~gather_en;
   assign merge_ok = st_valid & ~excl & same & ~blocked;

   // the open gather must go out before anything that cannot join it
   assign close_want = g_open & (blocked | (st_valid & ~merge_ok));
   assign flush_fire = close_want & out_free;
   assign close_set  = barrier & g_open & ~flush_fire;

   always_comb begin
      if (merge_ok)    st_ready = 1'b1;
      else if (g_open) st_ready = 1'b0;
      else if (excl)   st_ready = out_free;
      else             st_ready = 1'b1;
   end

   always_comb begin
      act = ACT_NONE;
      if (st_valid && st_ready) begin
         if (merge_ok)  act = ACT_MERGE;
         else if (excl) act = ACT_DIRECT;
         else           act = ACT_OPEN;
      end
   end

   // R7: a pending or arriving barrier never lets a store join the old gather
   a_r7_no_merge_past_barrier: assert property (@(posedge clk) disable iff (!rst_n)
      (barrier || g_close_req) |-> act != ACT_MERGE);

   // R11: a store that opens or bypasses never overtakes an open gather
   a_r11_gather_first: assert property (@(posedge clk) disable iff (!rst_n)
      g_open |-> (act != ACT_DIRECT && act != ACT_OPEN));

endmodule

// File: rtl/sgb_gather_reg.sv
module sgb_gather_reg
   import sgb_pkg::*;
#(
   parameter int  CHUNK_BYTES = 32,
   parameter int  CH_W        = 27,
   parameter int  IDLE_W      = 10,
   parameter bit  IDLE_EN     = 1'b1,
   parameter int  OFF_W       = $clog2(CHUNK_BYTES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [IDLE_W-1:0]        idle_limit,
   input  st_act_e                  act,
   input  logic                     flush_fire,
   input  logic                     close_set,
   input  logic [CH_W-1:0]          st_chunk,
   input  logic [OFF_W:0]           st_end,
   input  logic [CHUNK_BYTES*8-1:0] lane_data,
   input  logic [CHUNK_BYTES-1:0]   lane_be,
   output logic                     g_open,
   output logic [CH_W-1:0]          g_base,
   output logic [CHUNK_BYTES*8-1:0] g_data,
   output logic [CHUNK_BYTES-1:0]   g_be,
   output logic [OFF_W:0]           g_next,
   output logic                     g_close_req,
   output logic                     g_full,
   output logic                     g_timeout
);

   localparam logic [OFF_W:0] FULL_MARK = (OFF_W+1)'(CHUNK_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         g_open      <= 1'b0;
         g_base      <= '0;
         g_data      <= '0;
         g_be        <= '0;
         g_next      <= '0;
         g_close_req <= 1'b0;
      end else if (flush_fire) begin
         g_open      <= 1'b0;
         g_data      <= '0;
         g_be        <= '0;
         g_close_req <= 1'b0;
      end else begin
         if (close_set) g_close_req <= 1'b1;
         case (act)
            ACT_OPEN: begin
               g_open <= 1'b1;
               g_base <= st_chunk;
               g_data <= lane_data;
               g_be   <= lane_be;
               g_next <= st_end;
            end
            ACT_MERGE: begin
               g_data <= g_data | lane_data;
               g_be   <= g_be | lane_be;
               g_next <= st_end;
            end
            default: ;
         endcase
      end
   end

   assign g_full = g_open && (g_next == FULL_MARK);

   if (IDLE_EN) begin : g_timer
      logic [IDLE_W-1:0] idle_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            idle_q <= '0;
         else if (flush_fire || act == ACT_OPEN || act == ACT_MERGE)
            idle_q <= '0;
         else if (g_open && idle_q != '1)
            idle_q <= idle_q + 1'b1;
      end
      assign g_timeout = g_open && (idle_q >= idle_limit);
   end else begin : g_no_timer
      assign g_timeout = 1'b0;
   end

   // R4: an open gather always holds at least one written lane
   a_r4_open_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
      g_open |-> g_be != '0);

   // R9: a full gather has its top lane written
   a_r9_full_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
      g_full |-> g_be[CHUNK_BYTES-1]);

endmodule

// File: rtl/sgb_out_stage.sv
module sgb_out_stage #(
   parameter int CHUNK_BYTES = 32,
   parameter int CH_W        = 27,
   parameter int OFF_W       = $clog2(CHUNK_BYTES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bw_ready,
   input  logic                     load_g,
   input  logic [CH_W-1:0]          g_base,
   input  logic [CHUNK_BYTES*8-1:0] g_data,
   input  logic [CHUNK_BYTES-1:0]   g_be,
   input  logic                     load_d,
   input  logic [CH_W-1:0]          d_chunk,
   input  logic [CHUNK_BYTES*8-1:0] d_data,
   input  logic [CHUNK_BYTES-1:0]   d_be,
   output logic                     out_free,
   output logic                     bw_valid,
   output logic [CH_W+OFF_W-1:0]    bw_addr,
   output logic [CHUNK_BYTES*8-1:0] bw_data,
   output logic [CHUNK_BYTES-1:0]   bw_be
);

   logic [CH_W-1:0] chunk_q;

   assign out_free = ~bw_valid | bw_ready;
   assign bw_addr  = {chunk_q, {OFF_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bw_valid <= 1'b0;
         chunk_q  <= '0;
         bw_data  <= '0;
         bw_be    <= '0;
      end else if (load_g) begin
         bw_valid <= 1'b1;
         chunk_q  <= g_base;
         bw_data  <= g_data;
         bw_be    <= g_be;
      end else if (load_d) begin
         bw_valid <= 1'b1;
         chunk_q  <= d_chunk;
         bw_data  <= d_data;
         bw_be    <= d_be;
      end else if (bw_ready) begin
         bw_valid <= 1'b0;
      end
   end

   // R12: a stalled write holds every field
   a_r12_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (bw_valid && !bw_ready) |=> (bw_valid && $stable(bw_addr) && $stable(bw_data) && $stable(bw_be)));

   // R4: no empty bus write is ever offered
   a_r4_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      bw_valid |-> bw_be != '0);

   // R12: the slot is never loaded while the previous write is stalled
   a_r12_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      (bw_valid && !bw_ready) |-> !(load_g || load_d));

endmodule

// File: rtl/store_gather_buf.sv
module store_gather_buf
   import sgb_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CHUNK_BYTES = 32,
   parameter int ST_BYTES    = 8,
   parameter int IDLE_W      = 10,
   parameter bit IDLE_EN     = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     gather_en,
   input  logic [IDLE_W-1:0]        idle_limit,
   input  logic                     st_valid,
   output logic                     st_ready,
   input  logic [ADDR_W-1:0]        st_addr,
   input  logic [ST_BYTES*8-1:0]    st_data,
   input  logic [1:0]               st_size,
   input  logic                     st_le,
   input  logic                     st_fp,
   input  logic                     barrier,
   output logic                     bw_valid,
   input  logic                     bw_ready,
   output logic [ADDR_W-1:0]        bw_addr,
   output logic [CHUNK_BYTES*8-1:0] bw_data,
   output logic [CHUNK_BYTES-1:0]   bw_be
);

   localparam int OFF_W  = $clog2(CHUNK_BYTES);
   localparam int CH_W   = ADDR_W - OFF_W;
   localparam int DATA_W = CHUNK_BYTES * 8;

   // elaboration-time parameter checks
   if (CHUNK_BYTES < 8 || (CHUNK_BYTES & (CHUNK_BYTES - 1)) != 0) begin : g_bad_chunk
      $error("CHUNK_BYTES must be a power of two of at least 8");
   end
   if (ST_BYTES < 2 || ST_BYTES > 8 || (ST_BYTES & (ST_BYTES - 1)) != 0
       || ST_BYTES > CHUNK_BYTES) begin : g_bad_store
      $error("ST_BYTES must be 2, 4 or 8 and not exceed CHUNK_BYTES");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must be wider than the chunk offset");
   end
   if (IDLE_W < 1) begin : g_bad_idle
      $error("IDLE_W must be at least 1");
   end

   logic [CH_W-1:0]   st_chunk;
   logic [OFF_W-1:0]  st_off;
   logic [OFF_W:0]    st_nbytes, st_end;
   logic [DATA_W-1:0] lane_data;
   logic [CHUNK_BYTES-1:0] lane_be;

   logic              g_open, g_close_req, g_full, g_timeout;
   logic [CH_W-1:0]   g_base;
   logic [DATA_W-1:0] g_data;
   logic [CHUNK_BYTES-1:0] g_be;
   logic [OFF_W:0]    g_next;

   st_act_e act;
   logic    flush_fire, close_set, out_free;

   assign st_chunk = st_addr[ADDR_W-1:OFF_W];
   assign st_off   = st_addr[OFF_W-1:0];
   assign st_end   = {1'b0, st_off} + st_nbytes;

   sgb_lane_place #(
      .CHUNK_BYTES (CHUNK_BYTES),
      .ST_BYTES    (ST_BYTES),
      .OFF_W       (OFF_W)
   ) u_place (
      .off       (st_off),
      .size      (st_size),
      .data      (st_data),
      .nbytes    (st_nbytes),
      .lane_data (lane_data),
      .lane_be   (lane_be)
   );

   sgb_gather_ctl #(
      .CH_W  (CH_W),
      .OFF_W (OFF_W)
   ) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .gather_en   (gather_en),
      .st_valid    (st_valid),
      .st_le       (st_le),
      .st_fp       (st_fp),
      .barrier     (barrier),
      .st_chunk    (st_chunk),
      .st_off      (st_off),
      .g_open      (g_open),
      .g_base      (g_base),
      .g_next      (g_next),
      .g_close_req (g_close_req),
      .g_full      (g_full),
      .g_timeout   (g_timeout),
      .out_free    (out_free),
      .st_ready    (st_ready),
      .act         (act),
      .flush_fire  (flush_fire),
      .close_set   (close_set)
   );

   sgb_gather_reg #(
      .CHUNK_BYTES (CHUNK_BYTES),
      .CH_W        (CH_W),
      .IDLE_W      (IDLE_W),
      .IDLE_EN     (IDLE_EN),
      .OFF_W       (OFF_W)
   ) u_gather (
      .clk         (clk),
      .rst_n       (rst_n),
      .idle_limit  (idle_limit),
      .act         (act),
      .flush_fire  (flush_fire),
      .close_set   (close_set),
      .st_chunk    (st_chunk),
      .st_end      (st_end),
      .lane_data   (lane_data),
      .lane_be     (lane_be),
      .g_open      (g_open),
      .g_base      (g_base),
      .g_data      (g_data),
      .g_be        (g_be),
      .g_next      (g_next),
      .g_close_req (g_close_req),
      .g_full      (g_full),
      .g_timeout   (g_timeout)
   );

   sgb_out_stage #(
      .CHUNK_BYTES (CHUNK_BYTES),
      .CH_W        (CH_W),
      .OFF_W       (OFF_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .bw_ready (bw_ready),
      .load_g   (flush_fire),
      .g_base   (g_base),
      .g_data   (g_data),
      .g_be     (g_be),
      .load_d   (act == ACT_DIRECT),
      .d_chunk  (st_chunk),
      .d_data   (lane_data),
      .d_be     (lane_be),
      .out_free (out_free),
      .bw_valid (bw_valid),
      .bw_addr  (bw_addr),
      .bw_data  (bw_data),
      .bw_be    (bw_be)
   );

   // R5: an accepted little-endian store leaves no gather behind it
   a_r5_le_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_ready && st_le) |=> !g_open);

   // R6: an accepted floating-point store leaves no gather behind it
   a_r6_fp_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_ready && st_fp) |=> !g_open);

   // R8: with merging off no gather survives an accepted store
   a_r8_disabled_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_ready && !gather_en) |=> !g_open);

   // R7: a barrier either sends the gather or marks it closed
   a_r7_barrier_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (barrier && g_open) |=> (!g_open || g_close_req));

   // R9: a full gather goes out as soon as the slot is free
   a_r9_full_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      (g_full && (!bw_valid || bw_ready)) |=> !g_open);

   // R10: an expired gather goes out as soon as the slot is free
   a_r10_timeout_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      (g_timeout && (!bw_valid || bw_ready)) |=> !g_open);

endmodule

// File: tb/store_gather_buf_bench.sv
module store_gather_buf_bench;

   localparam int ADDR_W = 32;
   localparam int CHUNK  = 32;
   localparam int STB    = 8;
   localparam int IDLE_W = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              gather_en = 1'b1;
   logic [IDLE_W-1:0] idle_limit = '1;
   logic              st_valid = 1'b0;
   logic              st_ready;
   logic [ADDR_W-1:0] st_addr = '0;
   logic [STB*8-1:0]  st_data = '0;
   logic [1:0]        st_size = '0;
   logic              st_le = 1'b0;
   logic              st_fp = 1'b0;
   logic              barrier = 1'b0;
   logic              bw_valid;
   logic              bw_ready = 1'b1;
   logic [ADDR_W-1:0] bw_addr;
   logic [CHUNK*8-1:0] bw_data;
   logic [CHUNK-1:0]  bw_be;

   always #10 clk = ~clk;   // 50 MHz

   store_gather_buf #(
      .ADDR_W (ADDR_W), .CHUNK_BYTES (CHUNK), .ST_BYTES (STB), .IDLE_W (IDLE_W), .IDLE_EN (1'b1)
   ) u_store_gather_buf (
      .clk (clk), .rst_n (rst_n), .gather_en (gather_en), .idle_limit (idle_limit),
      .st_valid (st_valid), .st_ready (st_ready), .st_addr (st_addr), .st_data (st_data),
      .st_size (st_size), .st_le (st_le), .st_fp (st_fp), .barrier (barrier),
      .bw_valid (bw_valid), .bw_ready (bw_ready), .bw_addr (bw_addr),
      .bw_data (bw_data), .bw_be (bw_be)
   );

   int checks = 0;
   int fails  = 0;

   function automatic void chk(input bit ok, input string tag, input logic [255:0] act,
                               input logic [255:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endfunction

   // expected lane placement of one store
   function automatic logic [255:0] pdata(input logic [31:0] a, input logic [1:0] sz,
                                          input logic [63:0] d);
      logic [255:0] r = '0;
      for (int i = 0; i < (1 << sz); i++) r[((a % 32) + i) * 8 +: 8] = d[i*8 +: 8];
      return r;
   endfunction

   function automatic logic [31:0] pbe(input logic [31:0] a, input logic [1:0] sz);
      logic [31:0] r = '0;
      for (int i = 0; i < (1 << sz); i++) r[(a % 32) + i] = 1'b1;
      return r;
   endfunction

   // observed bus writes
   logic [31:0]  obs_a[$];
   logic [255:0] obs_d[$];
   logic [31:0]  obs_b[$];
   // model-predicted bus writes
   logic [31:0]  exp_a[$];
   logic [255:0] exp_d[$];
   logic [31:0]  exp_b[$];

   bit           model_on = 1'b0;
   bit           m_open = 1'b0;
   logic [31:0]  m_base = '0;
   int           m_next = 0;
   logic [255:0] m_data = '0;
   logic [31:0]  m_be = '0;

   function automatic void m_flush();
      if (m_open) begin
         exp_a.push_back(m_base); exp_d.push_back(m_data); exp_b.push_back(m_be);
         m_open = 1'b0;
      end
   endfunction

   function automatic void m_store(input logic [31:0] a, input logic [1:0] sz,
                                   input logic [63:0] d, input bit le, input bit fp,
                                   input bit en);
      logic [31:0] base = a & ~32'd31;
      if (le || fp || !en) begin
         m_flush();
         exp_a.push_back(base); exp_d.push_back(pdata(a, sz, d)); exp_b.push_back(pbe(a, sz));
         return;
      end
      if (!(m_open && m_base == base && m_next == int'(a % 32))) begin
         m_flush();
         m_open = 1'b1; m_base = base; m_data = '0; m_be = '0;
      end
      m_data = m_data | pdata(a, sz, d);
      m_be   = m_be | pbe(a, sz);
      m_next = int'(a % 32) + (1 << sz);
      if (m_next == 32) m_flush();
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         if (bw_valid && bw_ready) begin
            obs_a.push_back(bw_addr); obs_d.push_back(bw_data); obs_b.push_back(bw_be);
         end
         if (model_on) begin
            if (barrier || !gather_en) m_flush();
            if (st_valid && st_ready) m_store(st_addr, st_size, st_data, st_le, st_fp, gather_en);
         end
      end
   end

   bit stall = 1'b0;
   bit rnd_ready = 1'b0;
   always @(negedge clk) bw_ready <= stall ? 1'b0 : (rnd_ready ? ($urandom % 4 != 0) : 1'b1);

   task automatic begin_store(input logic [31:0] a, input logic [1:0] sz, input logic [63:0] d,
                              input bit le, input bit fp);
      @(negedge clk);
      st_addr = a; st_size = sz; st_data = d; st_le = le; st_fp = fp; st_valid = 1'b1;
   endtask

   task automatic end_store();
      #1;
      while (!st_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      st_valid = 1'b0; st_le = 1'b0; st_fp = 1'b0;
   endtask

   task automatic store(input logic [31:0] a, input logic [1:0] sz, input logic [63:0] d,
                        input bit le, input bit fp);
      begin_store(a, sz, d, le, fp);
      end_store();
   endtask

   task automatic pulse_barrier();
      @(negedge clk); barrier = 1'b1;
      @(posedge clk); #1; barrier = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_obs();
      obs_a.delete(); obs_d.delete(); obs_b.delete();
   endtask

   task automatic chk_write(input string tag, input int idx, input logic [31:0] a,
                            input logic [31:0] be);
      if (idx < obs_a.size()) begin
         chk(obs_a[idx] == a, {tag, " addr"}, obs_a[idx], a);
         chk(obs_b[idx] == be, {tag, " byte enables"}, obs_b[idx], be);
      end else begin
         chk(1'b0, {tag, " missing write"}, obs_a.size(), idx + 1);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      logic [63:0] d0, d1, d2, d3;
      logic [31:0] cur;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1: reset state
      chk(bw_valid == 1'b0, "R1 bw_valid after reset", bw_valid, 0);
      chk(st_ready == 1'b1, "R1 st_ready after reset", st_ready, 1);

      // R2 R9 R4: four contiguous doublewords fill one chunk
      clear_obs();
      d0 = 64'h0706050403020100; d1 = 64'h0f0e0d0c0b0a0908;
      d2 = 64'h1716151413121110; d3 = 64'h1f1e1d1c1b1a1918;
      store(32'h1000, 2'd3, d0, 0, 0);
      store(32'h1008, 2'd3, d1, 0, 0);
      store(32'h1010, 2'd3, d2, 0, 0);
      store(32'h1018, 2'd3, d3, 0, 0);
      settle(6);
      chk(obs_a.size() == 1, "R9 full chunk sent without barrier", obs_a.size(), 1);
      chk_write("R2", 0, 32'h1000, 32'hffff_ffff);
      if (obs_d.size() > 0)
         chk(obs_d[0] == {d3, d2, d1, d0}, "R4 merged data", obs_d[0], {d3, d2, d1, d0});

      // R3: gaps and chunk crossing
      clear_obs();
      store(32'h2000, 2'd2, 64'h11, 0, 0);
      store(32'h2008, 2'd2, 64'h22, 0, 0);
      store(32'h201c, 2'd2, 64'h33, 0, 0);
      store(32'h2020, 2'd2, 64'h44, 0, 0);
      pulse_barrier(); settle(6);
      chk(obs_a.size() == 4, "R3 write count", obs_a.size(), 4);
      chk_write("R3 first", 0, 32'h2000, 32'h0000_000f);
      chk_write("R3 gap", 1, 32'h2000, 32'h0000_0f00);
      chk_write("R3 tail", 2, 32'h2000, 32'hf000_0000);
      chk_write("R3 next chunk", 3, 32'h2020, 32'h0000_000f);

      // R5: little-endian store stays alone
      clear_obs();
      store(32'h3000, 2'd1, 64'haaaa, 0, 0);
      store(32'h3002, 2'd1, 64'hbbbb, 1, 0);
      store(32'h3004, 2'd1, 64'hcccc, 0, 0);
      store(32'h3006, 2'd1, 64'hdddd, 0, 0);
      pulse_barrier(); settle(6);
      chk(obs_a.size() == 3, "R5 write count", obs_a.size(), 3);
      chk_write("R5 before", 0, 32'h3000, 32'h3);
      chk_write("R5 le store", 1, 32'h3000, 32'hc);
      chk_write("R5 after", 2, 32'h3000, 32'hf0);
      if (obs_d.size() > 1)
         chk(obs_d[1] == pdata(32'h3002, 2'd1, 64'hbbbb), "R5 le data", obs_d[1],
             pdata(32'h3002, 2'd1, 64'hbbbb));

      // R6: floating-point stores stay alone
      clear_obs();
      store(32'h3100, 2'd0, 64'h1, 0, 1);
      store(32'h3101, 2'd0, 64'h2, 0, 0);
      store(32'h3102, 2'd0, 64'h3, 0, 1);
      pulse_barrier(); settle(6);
      chk(obs_a.size() == 3, "R6 write count", obs_a.size(), 3);
      chk_write("R6 fp first", 0, 32'h3100, 32'h1);
      chk_write("R6 plain", 1, 32'h3100, 32'h2);
      chk_write("R6 fp last", 2, 32'h3100, 32'h4);

      // R7: barrier separates contiguous bytes
      clear_obs();
      store(32'h4000, 2'd0, 64'h5a, 0, 0);
      pulse_barrier();
      store(32'h4001, 2'd0, 64'h6b, 0, 0);
      store(32'h4002, 2'd0, 64'h7c, 0, 0);
      pulse_barrier(); settle(6);
      chk(obs_a.size() == 2, "R7 write count", obs_a.size(), 2);
      chk_write("R7 before barrier", 0, 32'h4000, 32'h1);
      chk_write("R7 after barrier", 1, 32'h4000, 32'h6);

      // R8: gathering disabled
      clear_obs();
      @(negedge clk); gather_en = 1'b0;
      store(32'h5000, 2'd2, 64'h1234, 0, 0);
      store(32'h5004, 2'd2, 64'h5678, 0, 0);
      settle(6);
      chk(obs_a.size() == 2, "R8 write count", obs_a.size(), 2);
      chk_write("R8 first", 0, 32'h5000, 32'hf);
      chk_write("R8 second", 1, 32'h5000, 32'hf0);
      @(negedge clk); gather_en = 1'b1;

      // R10: idle timeout
      clear_obs();
      @(negedge clk); idle_limit = 10'd4;
      store(32'h6000, 2'd1, 64'hbeef, 0, 0);
      settle(2);
      chk(obs_a.size() == 0, "R10 not sent early", obs_a.size(), 0);
      settle(13);
      chk(obs_a.size() == 1, "R10 sent after idle", obs_a.size(), 1);
      chk_write("R10 timed-out write", 0, 32'h6000, 32'h3);
      @(negedge clk); idle_limit = '1;

      // R12: back-pressure holds the output and the input
      clear_obs();
      stall = 1'b1; settle(2);
      store(32'h7000, 2'd3, 64'h1111, 1, 0);
      begin_store(32'h7008, 2'd3, 64'h2222, 1, 0);
      settle(3); #1;
      chk(st_ready == 1'b0, "R12 st_ready held low", st_ready, 0);
      chk(bw_valid == 1'b1, "R12 write held", bw_valid, 1);
      chk(bw_addr == 32'h7000, "R12 address steady", bw_addr, 32'h7000);
      chk(bw_be == 32'hff, "R12 enables steady", bw_be, 32'hff);
      stall = 1'b0;
      end_store();
      settle(6);
      chk(obs_a.size() == 2, "R12 no store lost", obs_a.size(), 2);
      chk_write("R12 second", 1, 32'h7000, 32'hff00);

      // R11: random traffic against the bench model
      clear_obs();
      rnd_ready = 1'b1;
      model_on = 1'b1;
      cur = 32'h8000;
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom % 100;
         if (r < 5) begin
            pulse_barrier();
         end else if (r < 8) begin
            @(negedge clk); gather_en = ~gather_en;
         end else begin
            logic [31:0] a;
            logic [1:0]  sz;
            sz = 2'($urandom % 4);
            a  = ($urandom % 100 < 65) ? cur : (32'h8000 | ($urandom % 256));
            a  = 32'h8000 | (a & 32'hff);
            while ((a & ((32'd1 << sz) - 1)) != 0) sz = sz - 2'd1;
            store(a, sz, {$urandom, $urandom}, ($urandom % 100) < 4, ($urandom % 100) < 4);
            cur = a + (32'd1 << sz);
            if ($urandom % 4 == 0) settle(1);
         end
      end
      @(negedge clk); gather_en = 1'b1;
      pulse_barrier();
      rnd_ready = 1'b0;
      settle(20);
      model_on = 1'b0;
      chk(obs_a.size() == exp_a.size(), "R11 random write count", obs_a.size(), exp_a.size());
      for (int i = 0; i < exp_a.size() && i < obs_a.size(); i++) begin
         chk(obs_a[i] == exp_a[i], "R11 random order addr", obs_a[i], exp_a[i]);
         chk(obs_b[i] == exp_b[i], "R4 random byte enables", obs_b[i], exp_b[i]);
         chk((obs_d[i] & {256{1'b1}}) == exp_d[i], "R2 random data", obs_d[i], exp_d[i]);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule